// File: doc/BRIEF.md
# Per-Access External Bus Requester

This block lets an internal access engine reach a shared external bus. It does so without holding that bus while idle. Whenever the engine wants an external transfer, the block raises a request to an outside arbiter. It waits for the grant and passes the grant through a two-flop synchronizer. It turns its output drivers on with every strobe negated, then runs the bus cycles of the access. After the last cycle it hands the bus back. Until the drivers are on, the bus pins stay in high impedance.

An access may need several bus cycles, for example a wide transfer to a narrow device or a 32-byte line burst. It may also be indivisible, such as the read and the write of an atomic test-and-set. In both cases the block keeps ownership for the whole sequence. Every bus cycle of one access runs under one grant. If an access carries the lock flag, ownership continues into the next access, and ends only when an access without the flag completes.

The controller is a Moore state machine with eight states:
- IDLE: no request, drivers off.
- REQUEST: request raised, waiting for the synchronized grant.
- GRANTED: grant seen for one cycle, drivers still off.
- ENABLE: drivers on, strobes negated.
- STROBE: one bus cycle active.
- GAP: strobe negated between cycles.
- HOLD: locked ownership kept between accesses.
- RELEASE: request dropped, drivers still on with strobes negated.

Its transitions are:
- IDLE→REQUEST: internal request with no stale grant.
- REQUEST→GRANTED: synchronized grant seen.
- GRANTED→ENABLE: grant still present.
- GRANTED→REQUEST: grant withdrawn.
- ENABLE→STROBE: always, one cycle later.
- STROBE→GAP: more cycles remain.
- GAP→STROBE: always, one cycle later.
- STROBE→HOLD: last cycle of a locked access.
- STROBE→RELEASE: last cycle of an unlocked access.
- HOLD→STROBE: next internal request.
- RELEASE→IDLE: always, one cycle later.

Top module: `pa_bus_requester`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ext_req_o, drv_en_o, strobe_o and acc_done_o are all 0.
- R2: With no internal request, ext_req_o and drv_en_o stay 0, and the bus is left undriven.
- R3: An internal request raises ext_req_o after the next rising edge. If a grant from the previous ownership is still visible at the synchronizer output, the request waits until that output reads 0.
- R4: The grant passes through two flops. A grant present before rising edge k turns drv_en_o on after edge k+3, and not earlier. In that first driven cycle strobe_o is 0.
- R5: If the synchronized grant drops after a single cycle, before the drivers are on, drv_en_o stays 0 and ext_req_o stays 1.
- R6: An access runs N = acc_beats_i + 1 bus cycles. Each bus cycle is one cycle with strobe_o at 1. Consecutive bus cycles are separated by exactly one cycle with strobe_o at 0.
- R7: In the cycle after the final bus cycle of an unlocked access, ext_req_o is 0, drv_en_o is still 1 and strobe_o is 0. In the cycle after that, drv_en_o is 0.
- R8: After the final bus cycle of an access with acc_lock_i at 1, ext_req_o and drv_en_o stay 1 with strobe_o at 0 until the next internal request. That request's first bus cycle follows one edge later, without new arbitration.
- R9: strobe_o is never 1 while drv_en_o is 0, and ext_req_o remains 1 through every bus cycle.
- R10: acc_done_o is a single-cycle pulse that coincides with the final bus cycle of each access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_req_i | input | 1 | Internal access request, held until acc_done_o |
| acc_beats_i | input | BEAT_W | Number of bus cycles of the access minus one |
| acc_lock_i | input | 1 | Keep ownership after this access for the next one |
| acc_done_o | output | 1 | Pulse with the final bus cycle of the access |
| ext_req_o | output | 1 | Bus request to the external arbiter |
| ext_gnt_i | input | 1 | Asynchronous grant from the external arbiter |
| drv_en_o | output | 1 | Output-driver enable; 0 leaves the bus in high impedance |
| strobe_o | output | 1 | Bus-cycle control strobe, active high |

## Verification
The assertions rely on four properties of the inputs:
- Once the drivers are on, the arbiter keeps the grant asserted until it sees the request fall.
- The access engine withdraws acc_req_i in the cycle after acc_done_o.
- acc_beats_i and acc_lock_i are stable while a request is pending.
- A grant is only presented while a request is outstanding.

The stimulus meets these by driving inputs on the falling edge. The modelled arbiter lowers its grant only in the cycle it observes ext_req_o low. The one deliberate exception is a single-cycle grant pulse, and it is applied only while the state machine is still waiting for the grant.

// File: rtl/pa_bus_pkg.sv
package pa_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_GRANTED,
        ST_ENABLE,
        ST_STROBE,
        ST_GAP,
        ST_HOLD,
        ST_RELEASE
    } bus_state_e;

endpackage

// File: rtl/pa_gnt_sync.sv
module pa_gnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= '0;
                else         stg_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= '0;
                else         stg_q <= {stg_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pa_beat_cnt.sv
module pa_beat_cnt #(
    parameter int BEAT_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] load_val_i,
    input  logic              dec_i,
    output logic              last_o
);

    logic [BEAT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_i |-> !last_o); // R6
    AST_LOAD_DEC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && dec_i)); // R6

endmodule

// File: rtl/pa_bus_fsm.sv
module pa_bus_fsm
    import pa_bus_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic acc_req_i,
    input  logic acc_lock_i,
    input  logic gnt_sync_i,
    input  logic last_i,
    output logic load_o,
    output logic dec_o,
    output logic acc_done_o,
    output logic ext_req_o,
    output logic drv_en_o,
    output logic strobe_o
);

    bus_state_e state_q, state_d;
    logic       lock_q;

    // state register and lock latch
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) lock_q <= acc_lock_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        dec_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_req_i && !gnt_sync_i) begin
                    state_d = ST_REQUEST;
                    load_o  = 1'b1;
                end
            end
            ST_REQUEST: begin
                if (gnt_sync_i) state_d = ST_GRANTED;
            end
            ST_GRANTED: begin
                state_d = gnt_sync_i ? ST_ENABLE : ST_REQUEST;
            end
            ST_ENABLE: begin
                state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (!last_i) begin
                    state_d = ST_GAP;
                    dec_o   = 1'b1;
                end else begin
                    state_d = lock_q ? ST_HOLD : ST_RELEASE;
                end
            end
            ST_GAP: begin
                state_d = ST_STROBE;
            end
            ST_HOLD: begin
                if (acc_req_i) begin
                    state_d = ST_STROBE;
                    load_o  = 1'b1;
                end
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ext_req_o  = 1'b0;
        drv_en_o   = 1'b0;
        strobe_o   = 1'b0;
        acc_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQUEST, ST_GRANTED: ext_req_o = 1'b1;
            ST_ENABLE, ST_GAP, ST_HOLD: begin
                ext_req_o = 1'b1;
                drv_en_o  = 1'b1;
            end
            ST_STROBE: begin
                ext_req_o  = 1'b1;
                drv_en_o   = 1'b1;
                strobe_o   = 1'b1;
                acc_done_o = last_i;
            end
            ST_RELEASE: drv_en_o = 1'b1;
            default: ;
        endcase
    end

    AST_NO_STALE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ext_req_o) |-> !$past(gnt_sync_i)); // R3
    AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drv_en_o) |-> $past(gnt_sync_i) && $past(gnt_sync_i, 2)); // R4
    AST_FIRST_DRIVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drv_en_o) |-> !strobe_o); // R4
    AST_QUIET_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(drv_en_o) |-> !$past(strobe_o) && !ext_req_o); // R7
    AST_REQ_DROP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_done_o && !lock_q |=> !ext_req_o && drv_en_o); // R7
    AST_LOCK_KEEPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_done_o && lock_q |=> ext_req_o && drv_en_o && !strobe_o); // R8
    AST_REQ_FALL_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ext_req_o) |-> $past(acc_done_o)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_done_o |=> !acc_done_o); // R10

endmodule

// File: rtl/pa_bus_requester.sv
module pa_bus_requester #(
    parameter int BEAT_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_req_i,
    input  logic [BEAT_W-1:0] acc_beats_i,
    input  logic              acc_lock_i,
    output logic              acc_done_o,
    output logic              ext_req_o,
    input  logic              ext_gnt_i,
    output logic              drv_en_o,
    output logic              strobe_o
);

    logic gnt_sync;
    logic cnt_load;
    logic cnt_dec;
    logic cnt_last;

    pa_gnt_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_gnt_i),
        .sync_o  (gnt_sync)
    );

    pa_beat_cnt #(
        .BEAT_W (BEAT_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (acc_beats_i),
        .dec_i      (cnt_dec),
        .last_o     (cnt_last)
    );

    pa_bus_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acc_req_i  (acc_req_i),
        .acc_lock_i (acc_lock_i),
        .gnt_sync_i (gnt_sync),
        .last_i     (cnt_last),
        .load_o     (cnt_load),
        .dec_o      (cnt_dec),
        .acc_done_o (acc_done_o),
        .ext_req_o  (ext_req_o),
        .drv_en_o   (drv_en_o),
        .strobe_o   (strobe_o)
    );

    AST_STROBE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> drv_en_o && ext_req_o); // R9

endmodule

// File: tb/pa_bus_requester_tb_top.sv
module pa_bus_requester_tb_top;

    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic [BW-1:0] acc_beats = '0;
    logic          acc_lock = 1'b0;
    logic          ext_gnt = 1'b0;
    logic          acc_done, ext_req, drv_en, strobe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pa_bus_requester #(.BEAT_W(BW), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .acc_req_i   (acc_req),
        .acc_beats_i (acc_beats),
        .acc_lock_i  (acc_lock),
        .acc_done_o  (acc_done),
        .ext_req_o   (ext_req),
        .ext_gnt_i   (ext_gnt),
        .drv_en_o    (drv_en),
        .strobe_o    (strobe)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // N bus cycles: samples alternate strobe 1/0, done on the last
    task automatic play(int n);
        for (int i = 0; i < 2 * n - 1; i++) begin
            nxt();
            chk("R6 strobe pattern", int'(strobe), (i % 2 == 0) ? 1 : 0);
            chk("R10 done pulse", int'(acc_done), (i == 2 * n - 2) ? 1 : 0);
            chk("R9 drivers on", int'(drv_en), 1);
            chk("R9 request held", int'(ext_req), 1);
            if (i == 2 * n - 2) acc_req = 1'b0;
        end
    endtask

    task automatic begin_access(int n, bit lk);
        acc_req   = 1'b1;
        acc_beats = BW'(n - 1);
        acc_lock  = lk;
        nxt();
        chk("R3 request raised", int'(ext_req), 1);
        chk("R3 drivers off", int'(drv_en), 0);
    endtask

    task automatic grant_and_run(int n1, int n2, int gdly, int hgap);
        for (int d = 0; d < gdly; d++) begin
            nxt();
            chk("R3 request waiting", int'(ext_req), 1);
            chk("R3 drivers off waiting", int'(drv_en), 0);
        end
        ext_gnt = 1'b1;
        for (int k = 0; k < 3; k++) begin
            nxt();
            chk("R4 drivers wait sync", int'(drv_en), 0);
        end
        nxt();
        chk("R4 drivers on", int'(drv_en), 1);
        chk("R4 strobe quiet", int'(strobe), 0);
        play(n1);
        if (n2 > 0) begin
            for (int h = 0; h <= hgap; h++) begin
                nxt();
                chk("R8 hold drive", int'(drv_en), 1);
                chk("R8 hold strobe", int'(strobe), 0);
                chk("R8 hold request", int'(ext_req), 1);
            end
            acc_req   = 1'b1;
            acc_beats = BW'(n2 - 1);
            acc_lock  = 1'b0;
            play(n2);
        end
        nxt();
        chk("R7 request dropped", int'(ext_req), 0);
        chk("R7 drivers kept", int'(drv_en), 1);
        chk("R7 strobe quiet", int'(strobe), 0);
        ext_gnt = 1'b0;
        nxt();
        chk("R7 drivers off", int'(drv_en), 0);
        chk("R7 request off", int'(ext_req), 0);
    endtask

    task automatic settle();
        for (int s = 0; s < 3; s++) begin
            nxt();
            chk("R2 idle request", int'(ext_req), 0);
            chk("R2 idle drivers", int'(drv_en), 0);
        end
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) nxt();
        chk("R1 request", int'(ext_req), 0);
        chk("R1 drivers", int'(drv_en), 0);
        chk("R1 strobe", int'(strobe), 0);
        chk("R1 done", int'(acc_done), 0);
        rst_n = 1'b1;
        nxt();
        chk("R1 request after", int'(ext_req), 0);
        chk("R1 drivers after", int'(drv_en), 0);
        settle();

        // single accesses, every length, several grant delays
        for (int n = 1; n <= (1 << BW); n++) begin
            for (int g = 0; g < 3; g++) begin
                begin_access(n, 1'b0);
                grant_and_run(n, 0, g, 0);
                settle();
            end
        end

        // locked pairs, R8
        for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
                for (int h = 0; h < 3; h++) begin
                    begin_access(a, 1'b1);
                    grant_and_run(a, b, 1, h);
                    settle();
                end
            end
        end

        // R5 one-cycle grant pulse keeps drivers off
        begin_access(2, 1'b0);
        ext_gnt = 1'b1;
        nxt();
        ext_gnt = 1'b0;
        for (int c = 0; c < 6; c++) begin
            nxt();
            chk("R5 drivers off", int'(drv_en), 0);
            chk("R5 request pending", int'(ext_req), 1);
        end
        grant_and_run(2, 0, 0, 0);

        // R3 back-to-back: stale synchronized grant delays the request
        acc_req   = 1'b1;
        acc_beats = BW'(0);
        acc_lock  = 1'b0;
        nxt();
        chk("R3 stale grant blocks", int'(ext_req), 0);
        nxt();
        chk("R3 request after clear", int'(ext_req), 1);
        grant_and_run(1, 0, 0, 0);
        settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule